// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps a short record of why the system last restarted, and that record survives the warm reset the watchdog triggers. It holds a sticky timeout flag and an 8-bit cause code. Software reads both through one status word. Clocking and the generation of the resets happen outside the block. It takes a true power-on reset (`por_n`), a warm system reset (`warm_rst_n`), a one-cycle watchdog expiry pulse, and a small software port. Software uses that port to post a fatal-error code and to read, and so clear, the status.

A signature register decides on every boot whether the restart is a cold power-up or a warm restart. It holds 0x55 in its first byte and 0xAA in its second. A control state machine leaves reset in `ST_CHECK` and inspects the signature.
- If the signature is missing, the machine moves to `ST_COLD`. It writes the signature and zeroes the reported cause.
- If the signature is present, the machine moves to `ST_WARM`. It copies the live cause code into the reported cause.

Both paths then load the live code with the timeout code 0xFF and go on to `ST_ARMED`. The machine stays there until the next reset. A fatal-error write from software replaces the live code. A reset that no software write explains therefore reports 0xFF on the following boot. Software uses code 0x01 for a foreground failure and 0x02 for a background failure.

Top module: `reset_cause_rec`

## Requirements
- R1: `ready` is low while either reset is asserted. It stays low at the first rising edge after both resets are released. It is high from the second rising edge onward (`ST_CHECK` then `ST_COLD`/`ST_WARM`, then `ST_ARMED`) and stays high until the next reset.
- R2: After a power-on reset the signature is absent. The block takes the cold path, and `status` reads flag 0 with cause 0x00.
- R3: A `wdt_expire` pulse sets the flag, which is `status[8]`, from the next clock edge on.
- R4: Assertion and release of `warm_rst_n` leaves the flag unchanged.
- R5: A `sw_rd` strobe while `ready` is high returns the current status in that cycle and clears the flag at that edge.
- R6: A `sw_rd` strobe in the same cycle as a `wdt_expire` pulse leaves the flag set.
- R7: On each initialization the live cause is loaded with 0xFF. A warm restart with no software write in between reports cause 0xFF in `status[7:0]`.
- R8: A `sw_wr` strobe while `ready` replaces the live cause with `sw_code`, for example 0x01 for a foreground failure or 0x02 for a background failure. The reported cause `status[7:0]` changes only at initialization. After the next warm restart it shows the written code.
- R9: The 16-bit signature 0x55 (first byte), 0xAA (second byte) is written on the cold path and survives warm resets. The block reaches `ready` only with the signature present, and a warm restart takes the warm path.
- R10: `sw_wr` and `sw_rd` strobes while `ready` is low are ignored. They neither change the cause reported after the next warm restart nor clear the flag.
- R11: A power-on reset clears the flag, the cause and the signature, even after a timeout.
- R12: When several codes are written before a restart, the last one written is the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| warm_rst_n | input | 1 | Warm system reset, active low; restarts the state machine only |
| wdt_expire | input | 1 | One-cycle watchdog timeout pulse |
| sw_wr | input | 1 | Software strobe posting a fatal-error code |
| sw_code | input | 8 | Fatal-error code written with `sw_wr` |
| sw_rd | input | 1 | Software read strobe; clears the flag |
| status | output | 9 | Bit 8 timeout flag, bits 7:0 reported reset cause |
| ready | output | 1 | High once initialization is done (`ST_ARMED`) |

## Verification
Faults in this block show up at the ports on the next restart, or on the next read of the status word.
- A flag that a warm reset clears, or that is lost when a read meets a pulse, shows `status[8]` low one edge after the event.
- A signature that is not retained sends the boot down the cold path, so the cause reads 0x00 instead of the code written before the restart.
- A preload that goes missing leaves a stale code where 0xFF belongs.

The bench therefore checks the status after each warm restart, and again one edge after each pulse or read.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    typedef enum logic [1:0] {
        ST_CHECK = 2'd0,
        ST_COLD  = 2'd1,
        ST_WARM  = 2'd2,
        ST_ARMED = 2'd3
    } rcr_state_e;

    localparam int unsigned CAUSE_W      = 8;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 8'h00;
    localparam logic [CAUSE_W-1:0] CAUSE_FG_FAIL = 8'h01;
    localparam logic [CAUSE_W-1:0] CAUSE_BG_FAIL = 8'h02;
    localparam logic [CAUSE_W-1:0] CAUSE_WDT     = 8'hFF;

    localparam logic [7:0] SIG_EVEN = 8'h55;
    localparam logic [7:0] SIG_ODD  = 8'hAA;

endpackage

// File: rtl/rcr_fsm.sv
module rcr_fsm
    import rcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_ok,
    output rcr_state_e state_o,
    output logic       sig_wr,
    output logic       cold_init,
    output logic       warm_init,
    output logic       armed
);

    rcr_state_e state_q;
    rcr_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHECK: state_d = sig_ok ? ST_WARM : ST_COLD;
            ST_COLD:  state_d = ST_ARMED;
            ST_WARM:  state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CHECK;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        sig_wr    = 1'b0;
        cold_init = 1'b0;
        warm_init = 1'b0;
        armed     = 1'b0;
        unique case (state_q)
            ST_CHECK: ;
            ST_COLD: begin
                sig_wr    = 1'b1;
                cold_init = 1'b1;
            end
            ST_WARM:  warm_init = 1'b1;
            ST_ARMED: armed     = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/rcr_signature.sv
module rcr_signature
    import rcr_pkg::*;
#(
    parameter int unsigned SIG_BYTES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic wr,
    output logic sig_ok
);

    logic [SIG_BYTES-1:0] match;

    for (genvar i = 0; i < SIG_BYTES; i++) begin : g_byte
        localparam logic [7:0] PATTERN = (i % 2 == 0) ? SIG_EVEN : SIG_ODD;
        logic [7:0] byte_q;

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)  byte_q <= 8'h00;
            else if (wr) byte_q <= PATTERN;
        end

        assign match[i] = (byte_q == PATTERN);
    end

    assign sig_ok = &match;

endmodule

// File: rtl/rcr_cause_store.sv
module rcr_cause_store
    import rcr_pkg::*;
#(
    parameter int unsigned CODE_W = 8,
    parameter logic [CODE_W-1:0] WDT_CODE = CODE_W'(CAUSE_WDT)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              armed,
    input  logic              cold_init,
    input  logic              warm_init,
    input  logic              sw_wr,
    input  logic [CODE_W-1:0] sw_code,
    input  logic              sw_rd,
    input  logic              wdt_expire,
    output logic              flag_o,
    output logic [CODE_W-1:0] last_o
);

    logic [CODE_W-1:0] live_q;
    logic [CODE_W-1:0] last_q;
    logic              flag_q;

    // live cause: preloaded on init, replaced by software while armed
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                     live_q <= '0;
        else if (cold_init | warm_init) live_q <= WDT_CODE;
        else if (armed && sw_wr)        live_q <= sw_code;
    end

    // reported cause: set only during initialization
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         last_q <= '0;
        else if (cold_init) last_q <= '0;
        else if (warm_init) last_q <= live_q;
    end

    // timeout flag: a pulse wins over a coinciding read
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              flag_q <= 1'b0;
        else if (wdt_expire)     flag_q <= 1'b1;
        else if (armed && sw_rd) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign last_o = last_q;

endmodule

// File: rtl/reset_cause_rec.sv
module reset_cause_rec
    import rcr_pkg::*;
#(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned SIG_BYTES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              wdt_expire,
    input  logic              sw_wr,
    input  logic [CODE_W-1:0] sw_code,
    input  logic              sw_rd,
    output logic [CODE_W:0]   status,
    output logic              ready
);

    localparam logic [CODE_W-1:0] WDT_CODE = CODE_W'(CAUSE_WDT);

    logic       fsm_rst_n;
    logic       sig_ok;
    logic       sig_wr;
    logic       cold_init;
    logic       warm_init;
    logic       armed;
    rcr_state_e state;
    logic              flag;
    logic [CODE_W-1:0] last;

    assign fsm_rst_n = por_n & warm_rst_n;

    rcr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (fsm_rst_n),
        .sig_ok    (sig_ok),
        .state_o   (state),
        .sig_wr    (sig_wr),
        .cold_init (cold_init),
        .warm_init (warm_init),
        .armed     (armed)
    );

    rcr_signature #(.SIG_BYTES(SIG_BYTES)) u_sig (
        .clk    (clk),
        .por_n  (por_n),
        .wr     (sig_wr),
        .sig_ok (sig_ok)
    );

    rcr_cause_store #(.CODE_W(CODE_W), .WDT_CODE(WDT_CODE)) u_store (
        .clk        (clk),
        .por_n      (por_n),
        .armed      (armed),
        .cold_init  (cold_init),
        .warm_init  (warm_init),
        .sw_wr      (sw_wr),
        .sw_code    (sw_code),
        .sw_rd      (sw_rd),
        .wdt_expire (wdt_expire),
        .flag_o     (flag),
        .last_o     (last)
    );

    assign status = {flag, last};
    assign ready  = armed;

endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
    parameter int unsigned CODE_W = 8
) (
    input logic            clk,
    input logic            por_n,
    input logic            warm_rst_n,
    input logic            wdt_expire,
    input logic            sw_rd,
    input logic            ready,
    input logic            sig_ok,
    input logic [CODE_W:0] status
);

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!por_n)
        wdt_expire |=> status[CODE_W]);

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
        (ready && sw_rd && !wdt_expire) |=> !status[CODE_W]);

    p_coincide_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
        (sw_rd && wdt_expire) |=> status[CODE_W]);

    p_ready_hold_r1: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        ready |=> ready);

    p_report_stable_r8: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        (ready && $past(ready)) |-> $stable(status[CODE_W-1:0]));

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (!ready && status[CODE_W]) |=> status[CODE_W]);

    p_sig_present_r9: assert property (@(posedge clk) disable iff (!por_n)
        ready |-> sig_ok);

endmodule

bind reset_cause_rec rcr_checker #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .wdt_expire (wdt_expire),
    .sw_rd      (sw_rd),
    .ready      (ready),
    .sig_ok     (sig_ok),
    .status     (status)
);

// File: tb/reset_cause_rec_test.sv
module reset_cause_rec_test;

    localparam int W = 8;
    localparam logic [2:0] OP_CHK = 3'd0, OP_WDT = 3'd1, OP_WARM = 3'd2,
                           OP_WR = 3'd3, OP_RD = 3'd4;
    localparam int NV = 22;
    // entry: op[19:17] data[16:9] expected status[8:0]
    localparam logic [19:0] TBL [0:NV-1] = '{
        {OP_CHK,  8'h00, 9'h000},   // R2 cold boot
        {OP_WDT,  8'h00, 9'h000},
        {OP_CHK,  8'h00, 9'h100},   // R3
        {OP_WARM, 8'h00, 9'h000},
        {OP_CHK,  8'h00, 9'h1FF},   // R4 R7
        {OP_RD,   8'h00, 9'h1FF},   // R5
        {OP_CHK,  8'h00, 9'h0FF},   // R5
        {OP_WR,   8'h01, 9'h000},
        {OP_WARM, 8'h00, 9'h000},
        {OP_CHK,  8'h00, 9'h001},   // R8 foreground
        {OP_WR,   8'h02, 9'h000},
        {OP_WARM, 8'h00, 9'h000},
        {OP_CHK,  8'h00, 9'h002},   // R8 background
        {OP_WR,   8'h05, 9'h000},
        {OP_WR,   8'h09, 9'h000},
        {OP_WDT,  8'h00, 9'h000},
        {OP_WARM, 8'h00, 9'h000},
        {OP_CHK,  8'h00, 9'h109},   // R12 R9
        {OP_WARM, 8'h00, 9'h000},
        {OP_CHK,  8'h00, 9'h1FF},   // R7 R4
        {OP_RD,   8'h00, 9'h1FF},
        {OP_CHK,  8'h00, 9'h0FF}
    };

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         warm_rst_n = 1'b1;
    logic         wdt_expire = 1'b0;
    logic         sw_wr = 1'b0;
    logic [W-1:0] sw_code = '0;
    logic         sw_rd = 1'b0;
    logic [W:0]   status;
    logic         ready;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    reset_cause_rec uut (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .wdt_expire (wdt_expire),
        .sw_wr      (sw_wr),
        .sw_code    (sw_code),
        .sw_rd      (sw_rd),
        .status     (status),
        .ready      (ready)
    );

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // release a reset at a negedge, then check ready timing
    task automatic wait_ready(input string req);
        @(negedge clk);
        check(req, {8'h00, ready}, 9'h000);
        @(negedge clk);
        check(req, {8'h00, ready}, 9'h001);
    endtask

    task automatic do_warm();
        @(negedge clk) warm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        warm_rst_n = 1'b1;
        wait_ready("R1 warm");
    endtask

    task automatic do_por();
        @(negedge clk) por_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 por", {8'h00, ready}, 9'h000);
        por_n = 1'b1;
        wait_ready("R1 por");
    endtask

    task automatic pulse_wdt();
        wdt_expire = 1'b1;
        @(negedge clk) wdt_expire = 1'b0;
    endtask

    task automatic write_code(input logic [W-1:0] c);
        sw_wr = 1'b1; sw_code = c;
        @(negedge clk) sw_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // power-on: ready low, then cold path
        repeat (3) @(negedge clk);
        check("R1 in reset", {8'h00, ready}, 9'h000);
        por_n = 1'b1;
        wait_ready("R1 first boot");

        // table walk: R2 R3 R4 R5 R7 R8 R9 R12
        for (int i = 0; i < NV; i++) begin
            logic [2:0]   op;
            logic [W-1:0] d;
            logic [W:0]   e;
            op = TBL[i][19:17];
            d  = TBL[i][16:9];
            e  = TBL[i][8:0];
            case (op)
                OP_CHK:  check($sformatf("table %0d R2/R3/R4/R5/R7/R8/R12", i), status, e);
                OP_WDT:  pulse_wdt();
                OP_WARM: do_warm();
                OP_WR:   write_code(d);
                OP_RD: begin
                    check($sformatf("table %0d R5 read data", i), status, e);
                    sw_rd = 1'b1;
                    @(negedge clk) sw_rd = 1'b0;
                end
                default: ;
            endcase
        end

        // R6: read coinciding with a pulse keeps the flag
        wdt_expire = 1'b1; sw_rd = 1'b1;
        @(negedge clk) begin wdt_expire = 1'b0; sw_rd = 1'b0; end
        check("R6 coincident", {status[W], 8'h00}, 9'h100);
        sw_rd = 1'b1;
        @(negedge clk) sw_rd = 1'b0;
        check("R5 clear after R6", {status[W], 8'h00}, 9'h000);

        // R10: strobes while not ready are ignored
        pulse_wdt();
        @(negedge clk) warm_rst_n = 1'b0;
        sw_wr = 1'b1; sw_code = 8'h33; sw_rd = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 flag during reset", {status[W], 8'h00}, 9'h100);
        warm_rst_n = 1'b1;
        @(negedge clk);
        check("R10 flag during init", {status[W], 8'h00}, 9'h100);
        sw_wr = 1'b0; sw_rd = 1'b0;
        @(negedge clk);
        check("R10 after restart", status, 9'h1FF);
        do_warm();
        check("R10 ignored write", status, 9'h1FF);

        // R8: a write while armed does not move the reported cause
        write_code(8'h01);
        check("R8 report stable", status, 9'h1FF);

        // R11: power-on clears everything, cold path again
        do_por();
        check("R11 R2 after por", status, 9'h000);
        do_warm();
        check("R9 warm path after cold", status, 9'h0FF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule